// File: doc/BRIEF.md
# UART Interrupt Flag Generator

This block turns FIFO occupancy figures and receiver event strobes into a set of sticky interrupt status bits for a serial port. It compares the transmit and receive FIFO levels against programmable thresholds. It flags a receive overrun, parity and framing errors, changes on the clear-to-send input, and the start and end of a break sequence. It also runs an idle receive timer that fires when characters stop arriving while data still waits in the receive FIFO.

Each status bit stays set until software writes a one to its position. A per-source enable mask selects which bits drive a single registered interrupt line. The receiver, transmitter, FIFOs and bus logic sit outside the block and only present levels and single-cycle strobes to it.

Top module: `uart_irq_gen`

## Requirements
- R1: Status bit 0 (transmit level) sets in any cycle where `tx_level` is less than or equal to `tx_thresh`.
- R2: Status bit 1 (receive level) sets in any cycle where `rx_level` is greater than or equal to `rx_thresh`.
- R3: Status bit 2 (overrun) sets when `rx_char_stb` is high while `rx_full` is high.
- R4: Status bit 3 (clear-to-send change) sets once for each rising and each falling transition of `cts_in`, after a two-flop synchronizer; a steady level does not set it again.
- R5: Status bit 4 sets on a `rx_par_err` strobe and status bit 5 sets on a `rx_frm_err` strobe; each strobe touches only its own bit.
- R6: Status bit 6 (idle timeout) sets once, `tmo_limit` cycles after the most recent `rx_char_stb`, provided `rx_level` stays non-zero and `tmo_limit` is non-zero; it does not set again until another character arrives, never sets while `rx_level` is zero and never sets when `tmo_limit` is zero.
- R7: Status bit 7 sets when a character arrives with `rx_break` high and the previous character (or reset) had `rx_break` low; status bit 8 sets when a character arrives with `rx_break` low and the previous character had `rx_break` high. Further break characters within a sequence set neither bit.
- R8: Status bits are sticky; a cycle with `clr_wr` high clears exactly the bits where `clr_mask` is one and leaves all other bits unchanged.
- R9: When a set condition and a clear of the same bit occur in one cycle, the bit ends up set.
- R10: `irq` equals the OR over all bits of `status` AND `int_en`, registered one clock later.
- R11: After synchronous reset `status` is all zeros and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| tx_thresh | input | LVL_W | Transmit level threshold |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_thresh | input | LVL_W | Receive level threshold |
| rx_full | input | 1 | Receive FIFO full |
| rx_char_stb | input | 1 | One-cycle strobe per received character |
| rx_break | input | 1 | Qualifies the current character as a break character |
| rx_par_err | input | 1 | Parity error strobe |
| rx_frm_err | input | 1 | Missing start or stop bit strobe |
| cts_in | input | 1 | Asynchronous clear-to-send input |
| tmo_limit | input | TMO_W | Idle timeout in clock cycles, zero disables |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | NSRC | Bits to clear when `clr_wr` is high |
| int_en | input | NSRC | Per-source interrupt enable |
| status | output | NSRC | Sticky status bits |
| irq | output | 1 | Combined registered interrupt |

## Verification
The embedded properties assume that `rx_char_stb`, `rx_par_err` and `rx_frm_err` are synchronous to `clk` and that `rx_break` is only meaningful alongside a character strobe; only `cts_in` may change at arbitrary times. The bench drives every input on the falling edge, keeps all strobes one cycle wide, and returns to a quiet state (transmit level above its threshold, empty receive FIFO, timeout disabled) between random trials so that each trial's expected status is a pure function of that trial's inputs. The timeout and break trials run as directed sequences because their expected bits depend on history rather than on one cycle's inputs.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt flag generator.
// Bit positions here are the software-visible status layout.
package uart_irq_pkg;
    localparam int NSRC        = 9;
    localparam int SRC_TXLVL   = 0;
    localparam int SRC_RXLVL   = 1;
    localparam int SRC_OVR     = 2;
    localparam int SRC_CTS     = 3;
    localparam int SRC_PAR     = 4;
    localparam int SRC_FRM     = 5;
    localparam int SRC_TMO     = 6;
    localparam int SRC_BRK_ON  = 7;
    localparam int SRC_BRK_OFF = 8;
endpackage

// File: rtl/uart_irq_cts_sync.sv
// Synchronizes the asynchronous clear-to-send input with two flops and
// produces a one-cycle pulse on each transition of the synchronized level.
// Assumes: the input may change at any time; reset level of the chain is 1
// (idle, transmit allowed), so a low input after reset reports one change.
module uart_irq_cts_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_i,
    output logic chg_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-flop synchronizer followed by a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= cts_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Either edge of the synchronized level is a change.
    assign chg_o = sync_q ^ prev_q;

    // R4: a change pulse is followed by no pulse unless the input toggled again.
    p_cts_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_o && $stable(meta_q)) |=> !chg_o);
endmodule

// File: rtl/uart_irq_timeout.sv
// Idle receive timer. Restarts on each received character, counts clock
// cycles while the receive FIFO holds data and the limit is non-zero, and
// issues one registered pulse per idle period when the limit is reached.
// Assumes: the character strobe is one cycle wide and synchronous.
module uart_irq_timeout #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_stb_i,
    input  logic             nonempty_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             fire_o
);
    logic [TMO_W-1:0] cnt_q;
    logic             armed_q;
    logic             fire_q;
    logic             run;
    logic             hit;

    assign run = armed_q && nonempty_i && (limit_i != '0);
    assign hit = (cnt_q == limit_i - 1'b1);

    // Counter, arm flag and single-shot fire pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (char_stb_i) begin
                cnt_q   <= '0;
                armed_q <= 1'b1;
            end else if (run) begin
                if (hit) begin
                    fire_q  <= 1'b1;
                    armed_q <= 1'b0;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign fire_o = fire_q;

    // R6: at most one pulse per idle period.
    p_tmo_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);
    // R6: never fires from an empty FIFO.
    p_tmo_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> $past(nonempty_i));
endmodule

// File: rtl/uart_irq_status.sv
// Sticky status register with write-one-to-clear, set-over-clear priority,
// and a registered combined interrupt built from the enable mask.
// Assumes: set pulses and clear writes are synchronous to clk.
module uart_irq_status #(
    parameter int NSRC = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_wr_i,
    input  logic [NSRC-1:0] clr_mask_i,
    input  logic [NSRC-1:0] int_en_i,
    output logic [NSRC-1:0] status_o,
    output logic            irq_o
);
    logic [NSRC-1:0] status_q;
    logic            irq_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic bit_q;
        logic clr_hit;

        assign clr_hit = clr_wr_i && clr_mask_i[i];

        // One sticky bit: set has priority over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= set_i[i] | (bit_q & ~clr_hit);
        end

        assign status_q[i] = bit_q;

        // R8: a set bit holds unless cleared.
        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !clr_hit) |=> status_q[i]);
        // R9: a set request always leaves the bit set.
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> status_q[i]);
    end

    // Combined interrupt, registered one cycle after the status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_q & int_en_i);
    end

    assign status_o = status_q;
    assign irq_o    = irq_q;

    // R10: irq tracks enabled status with one cycle of latency.
    p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(status_o & int_en_i))));
endmodule

// File: rtl/uart_irq_gen.sv
// UART interrupt flag generator (top). Forms the per-source set conditions
// from FIFO levels, receiver strobes, the synchronized clear-to-send input,
// break-sequence tracking and the idle timer, then feeds the sticky status.
// Assumes: all inputs except cts_in are synchronous to clk; rx_break is only
// sampled together with rx_char_stb.
module uart_irq_gen
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic             rx_full,
    input  logic             rx_char_stb,
    input  logic             rx_break,
    input  logic             rx_par_err,
    input  logic             rx_frm_err,
    input  logic             cts_in,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             clr_wr,
    input  logic [NSRC-1:0]  clr_mask,
    input  logic [NSRC-1:0]  int_en,
    output logic [NSRC-1:0]  status,
    output logic             irq
);
    logic [NSRC-1:0] set_vec;
    logic            cts_chg;
    logic            tmo_fire;
    logic            in_break_q;
    logic            brk_on;
    logic            brk_off;
    logic            rx_nonempty;

    assign rx_nonempty = (rx_level != '0);

    // Tracks whether the last received character was a break character.
    always_ff @(posedge clk) begin
        if (!rst_n)           in_break_q <= 1'b0;
        else if (rx_char_stb) in_break_q <= rx_break;
    end

    assign brk_on  = rx_char_stb &&  rx_break && !in_break_q;
    assign brk_off = rx_char_stb && !rx_break &&  in_break_q;

    uart_irq_cts_sync u_cts (
        .clk   (clk),
        .rst_n (rst_n),
        .cts_i (cts_in),
        .chg_o (cts_chg)
    );

    uart_irq_timeout #(.TMO_W(TMO_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_stb_i (rx_char_stb),
        .nonempty_i (rx_nonempty),
        .limit_i    (tmo_limit),
        .fire_o     (tmo_fire)
    );

    // Per-source set conditions in status bit order.
    always_comb begin
        set_vec              = '0;
        set_vec[SRC_TXLVL]   = (tx_level <= tx_thresh);
        set_vec[SRC_RXLVL]   = (rx_level >= rx_thresh);
        set_vec[SRC_OVR]     = rx_char_stb && rx_full;
        set_vec[SRC_CTS]     = cts_chg;
        set_vec[SRC_PAR]     = rx_par_err;
        set_vec[SRC_FRM]     = rx_frm_err;
        set_vec[SRC_TMO]     = tmo_fire;
        set_vec[SRC_BRK_ON]  = brk_on;
        set_vec[SRC_BRK_OFF] = brk_off;
    end

    uart_irq_status #(.NSRC(NSRC)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .clr_wr_i   (clr_wr),
        .clr_mask_i (clr_mask),
        .int_en_i   (int_en),
        .status_o   (status),
        .irq_o      (irq)
    );

    // R1: transmit level at or below threshold reaches status.
    p_txlvl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= tx_thresh) |=> status[SRC_TXLVL]);
    // R2: receive level at or above threshold reaches status.
    p_rxlvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= rx_thresh) |=> status[SRC_RXLVL]);
    // R3: a character into a full FIFO flags overrun.
    p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_stb && rx_full) |=> status[SRC_OVR]);
    // R7: a second consecutive break character raises no start event.
    p_brk_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_stb && rx_break) |=> !(rx_char_stb && rx_break) || !brk_on);
    // R11: status is clear right after reset.
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && !irq));
endmodule

// File: tb/uart_irq_gen_tb_top.sv
module uart_irq_gen_tb_top;
    localparam int LVL_W = 5;
    localparam int TMO_W = 16;
    localparam int NS    = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] tx_level, tx_thresh, rx_level, rx_thresh;
    logic             rx_full, rx_char_stb, rx_break, rx_par_err, rx_frm_err;
    logic             cts_in;
    logic [TMO_W-1:0] tmo_limit;
    logic             clr_wr;
    logic [NS-1:0]    clr_mask, int_en;
    logic [NS-1:0]    status;
    logic             irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_irq_gen #(.LVL_W(LVL_W), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .tx_thresh(tx_thresh),
        .rx_level(rx_level), .rx_thresh(rx_thresh),
        .rx_full(rx_full), .rx_char_stb(rx_char_stb), .rx_break(rx_break),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .cts_in(cts_in), .tmo_limit(tmo_limit),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .int_en(int_en),
        .status(status), .irq(irq)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Inputs that set no status bit.
    task automatic quiet();
        tx_level = 5'd8;  tx_thresh = 5'd2;
        rx_level = 5'd0;  rx_thresh = 5'd4;
        rx_full = 1'b0; rx_char_stb = 1'b0; rx_break = 1'b0;
        rx_par_err = 1'b0; rx_frm_err = 1'b0;
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic clear_all();
        clr_wr = 1'b1; clr_mask = '1;
        step();
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic char_pulse(input logic brk);
        rx_char_stb = 1'b1; rx_break = brk;
        step();
        rx_char_stb = 1'b0; rx_break = 1'b0;
    endtask

    function automatic logic [NS-1:0] exp_fn(
        input logic [LVL_W-1:0] txl, txt, rxl, rxt,
        input logic full, chr, par, frm);
        logic [NS-1:0] e = '0;
        e[0] = (txl <= txt);
        e[1] = (rxl >= rxt);
        e[2] = full && chr;
        e[4] = par;
        e[5] = frm;
        return e;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        quiet();
        cts_in = 1'b1; tmo_limit = '0; int_en = '0;
        step(3);
        chk("R11 status after reset", status, 0);
        chk("R11 irq after reset", irq, 0);
        rst_n = 1'b1;
        step(4);
        chk("R11 quiet stays clear", status, 0);

        // Random trials for R1 R2 R3 R5.
        for (int it = 0; it < 60; it++) begin
            logic [LVL_W-1:0] a, b, c, d;
            logic f, ch, p, fr;
            a = LVL_W'($urandom_range(0, 16)); b = LVL_W'($urandom_range(0, 16));
            c = LVL_W'($urandom_range(1, 16)); d = LVL_W'($urandom_range(1, 16));
            f = 1'($urandom); ch = 1'($urandom); p = 1'($urandom); fr = 1'($urandom);
            clear_all();
            tx_level = a; tx_thresh = b; rx_level = c; rx_thresh = d;
            rx_full = f; rx_char_stb = ch; rx_par_err = p; rx_frm_err = fr;
            step();
            quiet();
            step();
            chk("R1/R2/R3/R5 random trial", status, exp_fn(a, b, c, d, f, ch, p, fr));
        end

        // R1 boundary: equal levels set, one above does not.
        clear_all(); tx_level = 5'd3; tx_thresh = 5'd3; step(); quiet(); step();
        chk("R1 tx equal", status, 9'h001);
        clear_all(); tx_level = 5'd4; tx_thresh = 5'd3; step(); quiet(); step();
        chk("R1 tx above", status, 9'h000);
        // R2 boundary.
        clear_all(); rx_level = 5'd6; rx_thresh = 5'd6; step(); quiet(); step();
        chk("R2 rx equal", status, 9'h002);
        clear_all(); rx_level = 5'd5; rx_thresh = 5'd6; step(); quiet(); step();
        chk("R2 rx below", status, 9'h000);
        // R3: full without a character is not overrun.
        clear_all(); rx_full = 1'b1; step(); quiet(); step();
        chk("R3 full no char", status, 9'h000);

        // R4: both edges, one event each.
        clear_all(); cts_in = 1'b0; step(5);
        chk("R4 cts fall", status, 9'h008);
        clear_all(); step(5);
        chk("R4 cts steady no repeat", status, 9'h000);
        cts_in = 1'b1; step(5);
        chk("R4 cts rise", status, 9'h008);

        // R8: partial clear keeps other bits.
        clear_all(); rx_par_err = 1'b1; rx_frm_err = 1'b1; step(); quiet(); step();
        chk("R5 par and frm", status, 9'h030);
        clr_wr = 1'b1; clr_mask = 9'h010; step(); quiet(); step();
        chk("R8 partial clear", status, 9'h020);
        step(3);
        chk("R8 sticky hold", status, 9'h020);

        // R9: set and clear in the same cycle.
        clear_all(); tx_level = 5'd1; tx_thresh = 5'd2; step();
        clr_wr = 1'b1; clr_mask = 9'h001; step();
        quiet(); step();
        chk("R9 set wins", status, 9'h001);

        // R10: irq follows enabled status one cycle later.
        int_en = 9'h002; step(2);
        chk("R10 irq masked", irq, 0);
        int_en = 9'h001; step();
        chk("R10 irq enabled", irq, 1);
        clear_all(); step();
        chk("R10 irq drops", irq, 0);
        int_en = '0;

        // R7: break sequence start and end.
        clear_all(); char_pulse(1'b1); step();
        chk("R7 first break", status, 9'h080);
        clear_all(); char_pulse(1'b1); step();
        chk("R7 repeat break silent", status, 9'h000);
        char_pulse(1'b0); step();
        chk("R7 last break", status, 9'h100);
        clear_all(); char_pulse(1'b0); step();
        chk("R7 normal char silent", status, 9'h000);

        // R6: idle timeout.
        clear_all(); rx_level = 5'd3; tmo_limit = 16'd20;
        char_pulse(1'b0); step(14);
        chk("R6 before limit", status[6], 0);
        step(10);
        chk("R6 after limit", status[6], 1);
        clear_all(); step(40);
        chk("R6 once per idle", status[6], 0);
        char_pulse(1'b0); rx_level = 5'd0; step(40);
        chk("R6 empty no fire", status[6], 0);
        rx_level = 5'd3; tmo_limit = '0; char_pulse(1'b0); step(40);
        chk("R6 zero limit no fire", status[6], 0);
        quiet(); step(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule